// File: doc/BRIEF.md
# Three-Digit Sequence Lock

This block is a clocked Mealy state machine that watches a stream of decimal digits and releases a lock once a fixed three-digit code arrives in consecutive valid digits. By default the code is 3, then 8, then 4. Each clock cycle the block may receive one binary-coded digit, qualified by a valid strobe. It drives one output, `unlock`.

Progress through the code is held in a two-bit state register with four states: idle (00), first digit seen (01), first two digits seen (10) and open (11). The final digit raises `unlock` in the same cycle that it is presented, because the output depends on both the current state and the input. The open state is absorbing and keeps `unlock` high until a synchronous reset. A first-digit value received part way through a partial match restarts the match at the first-digit-seen state instead of going back to idle. This means overlapping attempts such as 3 3 8 4 or 3 8 3 8 4 still open the lock.

The code digits and the digit width are parameters, and they are checked when the block is elaborated.

Top module: `code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state returns to idle. `unlock` is low for as long as `rst` is high, and it stays low after reset until a full code has been accepted.
- R2: From idle, a valid 3 moves to first-digit-seen. Any other valid digit leaves the machine in idle, with `unlock` low.
- R3: From first-digit-seen, a valid 8 moves to two-digits-seen. A valid 3 stays in first-digit-seen. Any other valid digit returns to idle.
- R4: From two-digits-seen, a valid 4 drives `unlock` high combinationally in the cycle that digit is presented, and it moves the machine to the open state at the next edge.
- R5: From two-digits-seen, a valid 3 moves to first-digit-seen, so a following 8, 4 opens the lock. Any other digit returns to idle, so a following 8, 4 does not open it.
- R6: The open state is absorbing. Once it is entered, `unlock` stays high for every input, valid or not, until reset.
- R7: In a cycle where `digit_valid` is low, the state does not change and `digit` is ignored. `unlock` then shows the resting value of the state: high only in the open state.
- R8: Digit codes 10 to 15 on the 4-bit `digit` input count as "any other digit" in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_valid | input | 1 | Qualifies `digit` for this cycle |
| digit | input | DIGIT_W (4) | Binary-coded decimal digit |
| unlock | output | 1 | Mealy open output |

## Verification
The bench drives several kinds of input. The plain code stream shows that the three transitions exist and that the Mealy output is timed correctly. Overlapping streams (3 3 8 4, and 3 8 3 8 4) separate a restart at the first-digit-seen state from a restart at idle. Broken streams (3 5 8 4, 3 8 5 4) show that a wrong digit clears progress. Streams broken up by invalid cycles, and streams carrying codes 10 to 15, check that stalls and out-of-range codes neither advance nor corrupt the match. A seeded random digit stream is compared against a small model of the requirements, and a run of arbitrary inputs after opening confirms that the open state absorbs everything.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

   typedef enum logic [1:0] {
      LK_IDLE = 2'b00,
      LK_GOT1 = 2'b01,
      LK_GOT2 = 2'b10,
      LK_OPEN = 2'b11
   } lock_state_t;

   localparam int unsigned CODE_LEN = 3;

endpackage

// File: rtl/code_lock_digit_match.sv
module code_lock_digit_match #(
   parameter int unsigned DIGIT_W  = 4,
   parameter int unsigned CODE_LEN = 3,
   parameter logic [CODE_LEN*DIGIT_W-1:0] CODE = '0
) (
   input  logic [DIGIT_W-1:0]  digit,
   output logic [CODE_LEN-1:0] hit
);

   for (genvar gi = 0; gi < CODE_LEN; gi++) begin : g_cmp
      assign hit[gi] = (digit == CODE[gi*DIGIT_W +: DIGIT_W]);
   end

endmodule

// File: rtl/code_lock_next.sv
module code_lock_next
   import code_lock_pkg::*;
(
   input  lock_state_t         cur,
   input  logic                valid,
   input  logic [CODE_LEN-1:0] hit,
   output lock_state_t         nxt,
   output logic                open_mealy
);

   always_comb begin
      nxt        = cur;
      open_mealy = 1'b0;
      unique case (cur)
         LK_IDLE: begin
            if (valid && hit[0]) nxt = LK_GOT1;
         end
         LK_GOT1: begin
            if (valid) begin
               if (hit[1])      nxt = LK_GOT2;
               else if (hit[0]) nxt = LK_GOT1;
               else             nxt = LK_IDLE;
            end
         end
         LK_GOT2: begin
            if (valid) begin
               if (hit[2]) begin
                  nxt        = LK_OPEN;
                  open_mealy = 1'b1;
               end
               else if (hit[0]) nxt = LK_GOT1;
               else             nxt = LK_IDLE;
            end
         end
         LK_OPEN: begin
            nxt        = LK_OPEN;
            open_mealy = 1'b1;
         end
         default: nxt = LK_IDLE;
      endcase
   end

endmodule

// File: rtl/code_lock.sv
module code_lock
   import code_lock_pkg::*;
#(
   parameter int unsigned DIGIT_W = 4,
   parameter logic [DIGIT_W-1:0] CODE_A = DIGIT_W'(3),
   parameter logic [DIGIT_W-1:0] CODE_B = DIGIT_W'(8),
   parameter logic [DIGIT_W-1:0] CODE_C = DIGIT_W'(4)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               digit_valid,
   input  logic [DIGIT_W-1:0] digit,
   output logic               unlock
);

   localparam logic [CODE_LEN*DIGIT_W-1:0] CODE_VEC = {CODE_C, CODE_B, CODE_A};

   initial begin
      a_cfg_width : assert (DIGIT_W >= 4)
         else $error("digit width must hold a decimal digit");
      a_cfg_distinct : assert (CODE_A != CODE_B && CODE_A != CODE_C)
         else $error("first code digit must differ from the others");
   end

   lock_state_t         state_q;
   lock_state_t         state_d;
   logic [CODE_LEN-1:0] hit;
   logic                open_comb;

   code_lock_digit_match #(
      .DIGIT_W  (DIGIT_W),
      .CODE_LEN (CODE_LEN),
      .CODE     (CODE_VEC)
   ) match_i (
      .digit (digit),
      .hit   (hit)
   );

   code_lock_next next_i (
      .cur        (state_q),
      .valid      (digit_valid),
      .hit        (hit),
      .nxt        (state_d),
      .open_mealy (open_comb)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= LK_IDLE;
      else     state_q <= state_d;
   end

   assign unlock = open_comb && !rst;

   // R2: a valid first digit from idle always lands in first-digit-seen
   a_r2_first_digit : assert property (@(posedge clk) disable iff (rst)
      (state_q == LK_IDLE && digit_valid && digit == CODE_A) |=> (state_q == LK_GOT1));

   // R4: final digit raises unlock at once and opens on the next edge
   a_r4_final_digit : assert property (@(posedge clk) disable iff (rst)
      (state_q == LK_GOT2 && digit_valid && digit == CODE_C) |-> unlock);
   a_r4_enter_open : assert property (@(posedge clk) disable iff (rst)
      (state_q == LK_GOT2 && digit_valid && digit == CODE_C) |=> (state_q == LK_OPEN));

   // R5: restart from two-digits-seen on the first digit
   a_r5_restart : assert property (@(posedge clk) disable iff (rst)
      (state_q == LK_GOT2 && digit_valid && digit == CODE_A) |=> (state_q == LK_GOT1));

   // R6: open state is absorbing
   a_r6_absorb : assert property (@(posedge clk) disable iff (rst)
      (state_q == LK_OPEN) |=> (state_q == LK_OPEN && unlock));

   // R7: no valid strobe, no movement
   a_r7_hold : assert property (@(posedge clk) disable iff (rst)
      !digit_valid |=> $stable(state_q));

endmodule

// File: tb/code_lock_tb_top.sv
module code_lock_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       digit_valid = 1'b0;
   logic [3:0] digit = 4'd0;
   logic       unlock;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   code_lock dut_i (
      .clk         (clk),
      .rst         (rst),
      .digit_valid (digit_valid),
      .digit       (digit),
      .unlock      (unlock)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (unlock !== exp) begin
         errors++;
         $display("FAIL %s: unlock=%b expected=%b at %0t", req, unlock, exp, $time);
      end
   endtask

   // present a digit after the falling edge, check the Mealy output, then let the rising edge take it
   task automatic feed(input logic v, input logic [3:0] d, input logic exp, input string req);
      @(negedge clk);
      digit_valid = v;
      digit       = d;
      #1;
      check(req, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      digit_valid = 1'b0;
      #1 check("R1 during reset", 1'b0);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      feed(1'b0, 4'd4, 1'b0, "R1 idle after reset");
      feed(1'b1, 4'd4, 1'b0, "R1 no open on lone 4");
   endtask

   task automatic t_plain_code();
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R2 first digit");
      feed(1'b1, 4'd8, 1'b0, "R3 second digit");
      feed(1'b1, 4'd4, 1'b1, "R4 final digit same cycle");
      feed(1'b0, 4'd0, 1'b1, "R4 open after edge");
   endtask

   task automatic t_idle_stays();
      do_reset();
      feed(1'b1, 4'd8, 1'b0, "R2 idle on 8");
      feed(1'b1, 4'd4, 1'b0, "R2 idle stays on 4");
   endtask

   task automatic t_overlap();
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R3 first 3");
      feed(1'b1, 4'd3, 1'b0, "R3 repeat 3");
      feed(1'b1, 4'd8, 1'b0, "R3 8 after 33");
      feed(1'b1, 4'd4, 1'b1, "R3 opens on 3384");
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R5 3");
      feed(1'b1, 4'd8, 1'b0, "R5 38");
      feed(1'b1, 4'd3, 1'b0, "R5 383");
      feed(1'b1, 4'd8, 1'b0, "R5 3838");
      feed(1'b1, 4'd4, 1'b1, "R5 opens on 38384");
   endtask

   task automatic t_broken();
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R3 3");
      feed(1'b1, 4'd5, 1'b0, "R3 wrong second");
      feed(1'b1, 4'd8, 1'b0, "R3 8 after reset to idle");
      feed(1'b1, 4'd4, 1'b0, "R3 3584 stays shut");
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R5 3");
      feed(1'b1, 4'd8, 1'b0, "R5 38");
      feed(1'b1, 4'd5, 1'b0, "R5 wrong third");
      feed(1'b1, 4'd4, 1'b0, "R5 3854 stays shut");
      feed(1'b1, 4'd8, 1'b0, "R5 idle on 8");
      feed(1'b1, 4'd4, 1'b0, "R5 idle on 4");
   endtask

   task automatic t_invalid_gaps();
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R7 3");
      feed(1'b0, 4'd9, 1'b0, "R7 gap ignores 9");
      feed(1'b1, 4'd8, 1'b0, "R7 8 after gap");
      feed(1'b0, 4'd4, 1'b0, "R7 invalid 4 no open");
      feed(1'b0, 4'd5, 1'b0, "R7 invalid 5 no effect");
      feed(1'b1, 4'd4, 1'b1, "R7 progress kept across gaps");
   endtask

   task automatic t_high_codes();
      do_reset();
      feed(1'b1, 4'd13, 1'b0, "R8 13 from idle");
      feed(1'b1, 4'd8, 1'b0, "R8 still idle");
      feed(1'b1, 4'd4, 1'b0, "R8 still idle on 4");
      feed(1'b1, 4'd3, 1'b0, "R8 3");
      feed(1'b1, 4'd8, 1'b0, "R8 38");
      feed(1'b1, 4'd12, 1'b0, "R8 12 as wrong third");
      feed(1'b1, 4'd4, 1'b0, "R8 no open after 12");
      feed(1'b1, 4'd3, 1'b0, "R8 3 again");
      feed(1'b1, 4'd11, 1'b0, "R8 11 as wrong second");
      feed(1'b1, 4'd8, 1'b0, "R8 8 after 11");
      feed(1'b1, 4'd4, 1'b0, "R8 still shut");
   endtask

   task automatic t_absorb();
      do_reset();
      feed(1'b1, 4'd3, 1'b0, "R6 3");
      feed(1'b1, 4'd8, 1'b0, "R6 8");
      feed(1'b1, 4'd4, 1'b1, "R6 4");
      for (int i = 0; i < 20; i++) begin
         feed(i[0], 4'(i % 16), 1'b1, "R6 absorbing");
      end
      do_reset();
      feed(1'b0, 4'd0, 1'b0, "R1 reset leaves open state");
   endtask

   task automatic t_random();
      int st;
      do_reset();
      st = 0;
      for (int i = 0; i < 400; i++) begin
         logic       v;
         logic [3:0] d;
         logic       e;
         v = ($urandom % 4) != 0;
         case ($urandom % 4)
            0: d = 4'd3;
            1: d = 4'd8;
            2: d = 4'd4;
            default: d = 4'($urandom % 16);
         endcase
         e = (st == 3) || (st == 2 && v && d == 4'd4);
         feed(v, d, e, "R2 R3 R4 R5 random stream");
         if (v && st != 3) begin
            if (st == 0)      st = (d == 4'd3) ? 1 : 0;
            else if (st == 1) st = (d == 4'd8) ? 2 : (d == 4'd3) ? 1 : 0;
            else              st = (d == 4'd4) ? 3 : (d == 4'd3) ? 1 : 0;
         end
         if (st == 3 && ($urandom % 8) == 0) begin
            do_reset();
            st = 0;
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_plain_code();
      t_idle_stays();
      t_overlap();
      t_broken();
      t_invalid_gaps();
      t_high_codes();
      t_absorb();
      t_random();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule